// File: doc/BRIEF.md
# Supply-Monitor Digital Filter and Status

This block sits between two analog supply comparators and the chip's reset logic. One comparator reports that the supply has dropped to or below the falling trip point. The other reports that the supply is above the rising trip point. The block removes supply noise from these two signals. A short dip does not cause a reset, but a sustained one does.

Two filters run side by side. The first counts CPU-cycle strobes to decide when to raise and drop a low-voltage reset request. It needs a long run of low samples to raise the request and only one high sample to drop it. The second counts oscillator-cycle strobes to qualify a status flag. It uses a longer window, and it keeps the flag's value while the supply sits between the two trip points. Software reads the flag through a one-byte, read-only status register on a simple read port.

Both comparator outputs are asynchronous, so each passes through a two-flop synchronizer before any counting. In this document, a "sample" means the synchronized value of an input.

Top module: `supmon_filter`

## Requirements
- R1: `lv_reset_o` rises after the synchronized "below falling trip" input has been high on 9 CPU strobes (`cpu_tick_i`) with no clock in between where it was low. It stays low when only 8 such strobes have occurred.
- R2: Once asserted, `lv_reset_o` falls after a single CPU strobe at which the synchronized "above rising trip" input is high. It does not fall while that input is high but no CPU strobe has occurred.
- R3: The status flag sets after the synchronized "below falling trip" input has been high on 36 oscillator strobes (`osc_tick_i`) with no interruption. It stays 0 after 35 such strobes.
- R4: The status flag clears whenever the synchronized "above rising trip" input is high. No strobe is needed for this.
- R5: While both synchronized comparator inputs are low (supply between the trip points), the status flag holds its previous value, whether that value is 0 or 1.
- R6: A read with `rd_en_i` high at address 0x3C returns the status byte on `rd_data_o` one clock later. The flag is in bit 7 and bits 6 to 0 read as 0.
- R7: While `rst_n` is low, `lv_reset_o`, the status flag and `rd_data_o` are all cleared, so the status byte reads 0x00 afterwards.
- R8: Any clock where the counted condition is false restarts that count from zero. An interrupted run therefore needs a full 9 (reset) or 36 (flag) fresh qualifying strobes.
- R9: A read at any address other than 0x3C returns 0x00, even while the flag is set.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| below_fall_i | input | 1 | Comparator: supply at or below falling trip (asynchronous) |
| above_rise_i | input | 1 | Comparator: supply above rising trip (asynchronous) |
| cpu_tick_i | input | 1 | One-clock strobe per CPU cycle |
| osc_tick_i | input | 1 | One-clock strobe per oscillator cycle |
| rd_en_i | input | 1 | Read request |
| rd_addr_i | input | 8 | Read address |
| rd_data_o | output | 8 | Read data, valid one clock after the request |
| lv_reset_o | output | 1 | Low-voltage reset request |

## Verification
The bench builds the block with its default parameters: 9 strobes to assert reset, 1 strobe to release it, 36 strobes to qualify the flag, and status address 0x3C. With a release count of 1, the bench can show that release waits for a strobe rather than happening at once. A 36-strobe window is short enough that the bench can drive runs of exactly one less than each threshold and exactly each threshold. It can also break a run partway through and show that the count starts over.

// File: rtl/supmon_pkg.sv
// Package: shared types for the supply-monitor filter.
// Assumes: nothing beyond the standard language.
package supmon_pkg;
    // Synchronized comparator pair.
    typedef struct packed {
        logic below;   // supply at or below falling trip
        logic above;   // supply above rising trip
    } supply_t;

    localparam int unsigned SUPPLY_W = $bits(supply_t);
endpackage

// File: rtl/supmon_sync.sv
// Module: two-flop synchronizer for a bus of independent level signals.
// Assumes: each bit changes slowly compared with clk, so the bits need not be coherent with each other.
module supmon_sync #(
    parameter int unsigned WIDTH = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] async_i,
    output logic [WIDTH-1:0] sync_o
);
    logic [WIDTH-1:0] meta_q;
    logic [WIDTH-1:0] sync_q;

    // Purpose: two register stages per bit, cleared by reset.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            meta_q <= '0;
            sync_q <= '0;
        end else begin
            meta_q <= async_i;
            sync_q <= meta_q;
        end
    end

    assign sync_o = sync_q;
endmodule

// File: rtl/supmon_debounce.sv
// Module: counts strobes on which a condition holds, and saturates at THRESH.
// Assumes: cond_i is synchronous. Any clock with cond_i low clears the count.
// qual_o is high while the count sits at THRESH.
module supmon_debounce #(
    parameter int unsigned THRESH = 9
) (
    input  logic clk,
    input  logic rst_n,
    input  logic tick_i,
    input  logic cond_i,
    output logic qual_o
);
    localparam int unsigned CW = $clog2(THRESH + 1);
    localparam logic [CW-1:0] LIMIT = CW'(THRESH);

    logic [CW-1:0] cnt_q;

    // Purpose: restart on a broken run, otherwise count strobes up to the limit.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (!cond_i) begin
            cnt_q <= '0;
        end else if (tick_i && (cnt_q != LIMIT)) begin
            cnt_q <= cnt_q + 1'b1;
        end
    end

    assign qual_o = (cnt_q == LIMIT);
endmodule

// File: rtl/supmon_status.sv
// Module: read-only status byte with a single flag in the top bit.
// Assumes: a read is a one-clock rd_en_i pulse. Data is registered and
// valid the clock after the request, then held until the next read.
module supmon_status #(
    parameter int unsigned     ADDR_W    = 8,
    parameter int unsigned     DATA_W    = 8,
    parameter logic [ADDR_W-1:0] REG_ADDR = 8'h3C
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              flag_i,
    input  logic              rd_en_i,
    input  logic [ADDR_W-1:0] rd_addr_i,
    output logic [DATA_W-1:0] rd_data_o
);
    localparam int unsigned FLAG_POS = DATA_W - 1;

    logic [DATA_W-1:0] status_byte;
    logic [DATA_W-1:0] rd_data_q;

    // Purpose: place the flag in the top bit; all other bits are zero.
    always_comb begin
        status_byte           = '0;
        status_byte[FLAG_POS] = flag_i;
    end

    // Purpose: register the read result; unmatched addresses return zero.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rd_data_q <= '0;
        end else if (rd_en_i) begin
            rd_data_q <= (rd_addr_i == REG_ADDR) ? status_byte : '0;
        end
    end

    assign rd_data_o = rd_data_q;
endmodule

// File: rtl/supmon_filter.sv
// Module: supply-monitor filter (top level).
// Synchronizes the comparator pair. One filter, counted on CPU strobes,
// drives the reset request. A second, slower filter, counted on oscillator
// strobes, drives the status flag, which holds while the supply is between the trip points.
// Assumes: strobes are one clock wide and synchronous to clk.
module supmon_filter #(
    parameter int unsigned ASSERT_CNT  = 9,
    parameter int unsigned RELEASE_CNT = 1,
    parameter int unsigned FLAG_CNT    = 36,
    parameter int unsigned ADDR_W      = 8,
    parameter int unsigned DATA_W      = 8,
    parameter logic [ADDR_W-1:0] STATUS_ADDR = 8'h3C
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              below_fall_i,
    input  logic              above_rise_i,
    input  logic              cpu_tick_i,
    input  logic              osc_tick_i,
    input  logic              rd_en_i,
    input  logic [ADDR_W-1:0] rd_addr_i,
    output logic [DATA_W-1:0] rd_data_o,
    output logic              lv_reset_o
);
    import supmon_pkg::*;

    supply_t raw_sup;
    supply_t sync_sup;
    logic    low_s;
    logic    high_s;
    logic    rst_qual;
    logic    rel_qual;
    logic    flag_qual;
    logic    rst_req_q;
    logic    status_flag;

    assign raw_sup.below = below_fall_i;
    assign raw_sup.above = above_rise_i;

    supmon_sync #(.WIDTH(SUPPLY_W)) u_sync (
        .clk     (clk),
        .rst_n   (rst_n),
        .async_i (raw_sup),
        .sync_o  (sync_sup)
    );

    assign low_s  = sync_sup.below;
    assign high_s = sync_sup.above;

    supmon_debounce #(.THRESH(ASSERT_CNT)) u_rst_assert (
        .clk (clk), .rst_n (rst_n), .tick_i (cpu_tick_i),
        .cond_i (low_s), .qual_o (rst_qual)
    );

    supmon_debounce #(.THRESH(RELEASE_CNT)) u_rst_release (
        .clk (clk), .rst_n (rst_n), .tick_i (cpu_tick_i),
        .cond_i (high_s), .qual_o (rel_qual)
    );

    supmon_debounce #(.THRESH(FLAG_CNT)) u_flag_qual (
        .clk (clk), .rst_n (rst_n), .tick_i (osc_tick_i),
        .cond_i (low_s), .qual_o (flag_qual)
    );

    // Purpose: reset request; assertion wins over release.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rst_req_q <= 1'b0;
        end else if (rst_qual && low_s) begin
            rst_req_q <= 1'b1;
        end else if (rel_qual && high_s) begin
            rst_req_q <= 1'b0;
        end
    end

    // Purpose: status flag; cleared above rising trip, set by a qualified low, held otherwise.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            status_flag <= 1'b0;
        end else if (high_s) begin
            status_flag <= 1'b0;
        end else if (flag_qual && low_s) begin
            status_flag <= 1'b1;
        end
    end

    supmon_status #(
        .ADDR_W (ADDR_W), .DATA_W (DATA_W), .REG_ADDR (STATUS_ADDR)
    ) u_status (
        .clk       (clk),
        .rst_n     (rst_n),
        .flag_i    (status_flag),
        .rd_en_i   (rd_en_i),
        .rd_addr_i (rd_addr_i),
        .rd_data_o (rd_data_o)
    );

    assign lv_reset_o = rst_req_q;
endmodule

// File: rtl/supmon_filter_chk.sv
// Module: assertion checker for supmon_filter, attached with bind.
// Independent run counters compare each output edge with the samples that led to it.
module supmon_filter_chk #(
    parameter int unsigned ASSERT_CNT  = 9,
    parameter int unsigned FLAG_CNT    = 36,
    parameter int unsigned ADDR_W      = 8,
    parameter int unsigned DATA_W      = 8,
    parameter logic [ADDR_W-1:0] STATUS_ADDR = 8'h3C
) (
    input logic              clk,
    input logic              rst_n,
    input logic              low_s,
    input logic              high_s,
    input logic              cpu_tick_i,
    input logic              osc_tick_i,
    input logic              rd_en_i,
    input logic [ADDR_W-1:0] rd_addr_i,
    input logic [DATA_W-1:0] rd_data_o,
    input logic              lv_reset_o,
    input logic              status_flag
);
    logic [15:0] low_cpu_run;
    logic [15:0] low_osc_run;
    logic        last_cpu_high;

    // Purpose: count consecutive low runs on each strobe, and remember the last CPU-strobe high sample.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            low_cpu_run   <= '0;
            low_osc_run   <= '0;
            last_cpu_high <= 1'b0;
        end else begin
            if (!low_s) low_cpu_run <= '0;
            else if (cpu_tick_i && low_cpu_run != 16'hFFFF) low_cpu_run <= low_cpu_run + 1'b1;
            if (!low_s) low_osc_run <= '0;
            else if (osc_tick_i && low_osc_run != 16'hFFFF) low_osc_run <= low_osc_run + 1'b1;
            if (!high_s) last_cpu_high <= 1'b0;
            else if (cpu_tick_i) last_cpu_high <= 1'b1;
        end
    end

    assert_rst_qualified_R1: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(lv_reset_o) |-> ($past(low_cpu_run) >= 16'(ASSERT_CNT)));

    assert_rst_release_R2: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(lv_reset_o) |-> $past(last_cpu_high));

    assert_flag_qualified_R3: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(status_flag) |-> ($past(low_osc_run) >= 16'(FLAG_CNT)));

    assert_flag_clear_R4: assert property (@(posedge clk) disable iff (!rst_n)
        high_s |=> !status_flag);

    assert_flag_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (!low_s && !high_s) |=> $stable(status_flag));

    assert_low_bits_zero_R6: assert property (@(posedge clk) disable iff (!rst_n)
        rd_data_o[DATA_W-2:0] == '0);

    assert_other_addr_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en_i && rd_addr_i != STATUS_ADDR) |=> rd_data_o == '0);
endmodule

bind supmon_filter supmon_filter_chk #(
    .ASSERT_CNT  (ASSERT_CNT),
    .FLAG_CNT    (FLAG_CNT),
    .ADDR_W      (ADDR_W),
    .DATA_W      (DATA_W),
    .STATUS_ADDR (STATUS_ADDR)
) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .low_s       (low_s),
    .high_s      (high_s),
    .cpu_tick_i  (cpu_tick_i),
    .osc_tick_i  (osc_tick_i),
    .rd_en_i     (rd_en_i),
    .rd_addr_i   (rd_addr_i),
    .rd_data_o   (rd_data_o),
    .lv_reset_o  (lv_reset_o),
    .status_flag (status_flag)
);

// File: tb/supmon_filter_bench.sv
// Bench: read results go through a scoreboard queue; reset-request checks are made directly.
module supmon_filter_bench;
    localparam logic [7:0] ADDR = 8'h3C;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       below_fall_i = 1'b0;
    logic       above_rise_i = 1'b1;
    logic       cpu_tick_i = 1'b0;
    logic       osc_tick_i = 1'b0;
    logic       rd_en_i = 1'b0;
    logic [7:0] rd_addr_i = 8'h00;
    logic [7:0] rd_data_o;
    logic       lv_reset_o;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    typedef struct {
        logic [7:0] exp;
        string      tag;
    } sb_item_t;
    sb_item_t sb_q[$];

    always #10 clk = ~clk;   // 50 MHz

    supmon_filter u_supmon_filter (
        .clk (clk), .rst_n (rst_n),
        .below_fall_i (below_fall_i), .above_rise_i (above_rise_i),
        .cpu_tick_i (cpu_tick_i), .osc_tick_i (osc_tick_i),
        .rd_en_i (rd_en_i), .rd_addr_i (rd_addr_i),
        .rd_data_o (rd_data_o), .lv_reset_o (lv_reset_o)
    );

    task automatic report();
        $display("%0d/%0d checks passed", checks - fails, checks);
    endtask

    task automatic check_rst(input logic exp, input string tag);
        checks++;
        if (lv_reset_o !== exp) begin
            fails++;
            $display("FAIL %s: lv_reset_o actual=%0b expected=%0b", tag, lv_reset_o, exp);
        end
    endtask

    // Driver: issue a read and push the expected byte.
    task automatic do_read(input logic [7:0] addr, input logic [7:0] exp, input string tag);
        @(negedge clk);
        sb_q.push_back('{exp: exp, tag: tag});
        rd_en_i   = 1'b1;
        rd_addr_i = addr;
        @(negedge clk);
        rd_en_i   = 1'b0;
        @(negedge clk);
    endtask

    // Monitor: compare the data that follows each read.
    initial begin
        forever begin
            @(posedge clk);
            if (rd_en_i) begin
                @(negedge clk);
                if (sb_q.size() == 0) begin
                    checks++; fails++;
                    $display("FAIL scoreboard: unexpected read, actual=%02h expected=none", rd_data_o);
                end else begin
                    sb_item_t it;
                    it = sb_q.pop_front();
                    checks++;
                    if (rd_data_o !== it.exp) begin
                        fails++;
                        $display("FAIL %s: rd_data_o actual=%02h expected=%02h", it.tag, rd_data_o, it.exp);
                    end
                end
            end
        end
    end

    // Set the comparator levels and wait until they are through the synchronizer.
    task automatic set_supply(input logic low, input logic high);
        @(negedge clk);
        below_fall_i = low;
        above_rise_i = high;
        repeat (3) @(negedge clk);
    endtask

    task automatic cpu_pulses(input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk); cpu_tick_i = 1'b1;
            @(negedge clk); cpu_tick_i = 1'b0;
        end
        @(negedge clk);
    endtask

    task automatic osc_pulses(input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk); osc_tick_i = 1'b1;
            @(negedge clk); osc_tick_i = 1'b0;
        end
        @(negedge clk);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        repeat (3) @(negedge clk);

        // R7: reset state; R6: register format
        check_rst(1'b0, "R7 reset state");
        do_read(ADDR, 8'h00, "R7 status after reset");

        // R1: 8 strobes do not assert; the 9th does
        set_supply(1'b1, 1'b0);
        cpu_pulses(8);
        check_rst(1'b0, "R1 eight strobes");
        cpu_pulses(1);
        check_rst(1'b1, "R1 nine strobes");

        // R2: release needs a strobe
        set_supply(1'b0, 1'b1);
        repeat (4) @(negedge clk);
        check_rst(1'b1, "R2 no strobe yet");
        cpu_pulses(1);
        check_rst(1'b0, "R2 one strobe");

        // R8: an interrupted run restarts the reset count
        set_supply(1'b1, 1'b0);
        cpu_pulses(5);
        set_supply(1'b0, 1'b0);
        set_supply(1'b1, 1'b0);
        cpu_pulses(8);
        check_rst(1'b0, "R8 restart reset count");
        cpu_pulses(1);
        check_rst(1'b1, "R8 full fresh run");
        set_supply(1'b0, 1'b1);
        cpu_pulses(1);
        check_rst(1'b0, "R2 release again");

        // R3: flag qualification
        set_supply(1'b1, 1'b0);
        osc_pulses(35);
        do_read(ADDR, 8'h00, "R3 thirty-five strobes");
        osc_pulses(1);
        do_read(ADDR, 8'h80, "R3 thirty-six strobes");
        do_read(8'h3D, 8'h00, "R9 other address");
        do_read(8'h00, 8'h00, "R9 address zero");

        // R5 hold at 1, R4 clear, R5 hold at 0
        set_supply(1'b0, 1'b0);
        repeat (10) @(negedge clk);
        do_read(ADDR, 8'h80, "R5 hold set");
        set_supply(1'b0, 1'b1);
        do_read(ADDR, 8'h00, "R4 clear above rising");
        set_supply(1'b0, 1'b0);
        do_read(ADDR, 8'h00, "R5 hold clear");

        // R8: an interrupted flag run restarts
        set_supply(1'b1, 1'b0);
        osc_pulses(30);
        set_supply(1'b0, 1'b0);
        set_supply(1'b1, 1'b0);
        osc_pulses(35);
        do_read(ADDR, 8'h00, "R8 restart flag count");
        osc_pulses(1);
        do_read(ADDR, 8'h80, "R8 flag fresh run");

        // R7: reset clears the flag
        @(negedge clk); rst_n = 1'b0;
        repeat (2) @(negedge clk); rst_n = 1'b1;
        do_read(ADDR, 8'h00, "R7 flag cleared by reset");
        check_rst(1'b0, "R7 request cleared by reset");

        repeat (4) @(negedge clk);
        if (sb_q.size() != 0) begin
            checks++; fails++;
            $display("FAIL scoreboard: %0d reads unanswered, expected 0", sb_q.size());
        end
        done = 1'b1;
        report();
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            checks++; fails++;
            $display("FAIL watchdog: run not finished, expected completion");
            report();
            $finish;
        end
    end
endmodule